// File: doc/BRIEF.md
# Two-Wire Bus Mode Control Register

This block holds the eight-bit control word of a two-wire serial interface that can act as bus master or slave. Software writes the word to set the enable, the receive-hold option, the master/slave and direction bits, and a four-bit clock selector. The bus engine beside it reports hardware events as single-cycle pulses: start seen, address matched (with the direction bit), arbitration lost, overrun, receive data read, and frame end. From these events the block moves the mode bits without software help.

Software writes to the direction bit that arrive inside a frame are held and applied at the next frame end. A hardware event and a software write that land in the same cycle resolve in favour of the hardware. The block drives the current mode, the pin-drive enable, a receive-allowed level, and a setup-wait level that covers the data setup time after the block enters slave transmit. It also gives a one-cycle arbitration-lost pulse and a sticky address-match flag.

Top module: `sbus_mode_ctrl`

## Requirements
- R1: After reset every control bit is 0. The mode is slave receive, pin drive and receive-allowed are low, and the setup-wait, arbitration pulse and match flag are low.
- R2: Control word layout: bit 7 enable, bit 6 receive hold, bit 5 master, bit 4 transmit, bits 3:0 clock select. A write takes effect on the clock edge that samples it, except as R7 and R9 state.
- R3: Mode output is {master, transmit}: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit. Pin drive equals the enable bit.
- R4: In master mode with the two-wire format (fmt_sync = 0), arbitration lost sets the mode to 00 on the next edge.
- R5: In master receive mode (10) with the clock-synchronous format (fmt_sync = 1), an overrun clears the master bit, giving mode 00. An overrun with fmt_sync = 0 leaves the mode unchanged.
- R6: In slave receive mode, an address match with the direction bit at 1 sets the mode to 01. With the direction bit at 0 the mode stays 00.
- R7: A write made while a frame is open (between a start pulse and a frame-end pulse) changes the transmit bit only at the frame end. A write to the master bit applies at once.
- R8: Entering slave transmit raises setup-wait for exactly 10 cycles when clock-select bit 3 is 0, and for exactly 20 cycles when it is 1.
- R9: When a hardware event changes the mode in the same cycle as a software write, the mode follows the hardware event.
- R10: Each arbitration loss that changes the mode gives a one-cycle pulse on arb_lost_o. An address match in slave receive mode sets match_flag_o, which stays set until a flag_clr pulse.
- R11: A data read with the transmit bit 0 and receive hold 1 drops rx_allow_o. A data read with receive hold 0, or a write with receive hold 0, raises it again.
- R12: While enable is 0, bus events have no effect on the mode, the match flag or the receive gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| flag_clr | input | 1 | Clears the address-match flag |
| fmt_sync | input | 1 | 1 = clock-synchronous format, 0 = two-wire format |
| ev_start | input | 1 | Start detected (opens a frame) |
| ev_frame_end | input | 1 | Frame boundary (closes a frame) |
| ev_addr_match | input | 1 | Received address equals own address |
| ev_addr_rw | input | 1 | Direction bit that came with the address |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_overrun | input | 1 | Receive overrun |
| ev_data_read | input | 1 | Receive data register was read |
| ctrl_o | output | 8 | Current control word |
| mode_o | output | 2 | Current {master, transmit} mode |
| pin_drive_o | output | 1 | Bus pins in drive state |
| rx_allow_o | output | 1 | Next reception allowed |
| setup_wait_o | output | 1 | Slave transmit setup time running |
| clk_sel_o | output | 4 | Clock selector for the rate divider |
| arb_lost_o | output | 1 | One-cycle arbitration-lost pulse |
| match_flag_o | output | 1 | Sticky address-match flag |

## Verification
The bench writes the direction bit inside an open frame. If a design applied it at once, the mode would change before the frame-end pulse. It drives a write and an arbitration loss in the same cycle, where a design with the wrong priority would end in master transmit instead of slave receive. It measures the setup-wait length for both values of clock-select bit 3, where an off-by-one counter gives 9/11 or 19/21 cycles. It also checks that overrun in the two-wire format is ignored, that a read-direction match is the only match that changes the mode, and that bus events have no effect while the block is disabled.

// File: rtl/sbus_mode_pkg.sv
package sbus_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } sbus_mode_e;

  localparam int unsigned CW_EN   = 7;
  localparam int unsigned CW_HOLD = 6;
  localparam int unsigned CW_MST  = 5;
  localparam int unsigned CW_TX   = 4;

  typedef struct packed {
    logic       en;
    logic       hold;
    logic       mst;
    logic       tx;
    logic [3:0] csel;
  } sbus_ctrl_t;

endpackage

// File: rtl/sbus_mode_fsm.sv
module sbus_mode_fsm
  import sbus_mode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wr_en,
  input  logic wr_mst,
  input  logic wr_tx,
  input  logic fmt_sync,
  input  logic ev_start,
  input  logic ev_frame_end,
  input  logic ev_addr_match,
  input  logic ev_addr_rw,
  input  logic ev_arb_lost,
  input  logic ev_overrun,
  output logic mst_q,
  output logic tx_q,
  output logic arb_pulse_q,
  output logic enter_stx
);

  logic in_frame_q;
  logic pend_v_q;
  logic pend_tx_q;

  logic arb_hit, ovr_hit, rd_hit, hw_hit;
  logic mst_n, tx_n, pend_v_n, pend_tx_n, in_frame_n;
  logic frame_open;

  assign arb_hit = en & ev_arb_lost & mst_q & ~fmt_sync;
  assign ovr_hit = en & ev_overrun & mst_q & ~tx_q & fmt_sync;
  assign rd_hit  = en & ev_addr_match & ev_addr_rw & ~mst_q & ~tx_q;
  assign hw_hit  = arb_hit | ovr_hit | rd_hit;

  // A frame still counts as open in the cycle that closes it only if
  // no frame-end pulse arrives; a write at the boundary applies directly.
  assign frame_open = in_frame_q & ~ev_frame_end;

  always_comb begin
    mst_n     = mst_q;
    tx_n      = tx_q;
    pend_v_n  = pend_v_q;
    pend_tx_n = pend_tx_q;

    if (ev_frame_end && pend_v_q) begin
      tx_n     = pend_tx_q;
      pend_v_n = 1'b0;
    end

    if (wr_en) begin
      mst_n = wr_mst;
      if (frame_open) begin
        pend_v_n  = 1'b1;
        pend_tx_n = wr_tx;
      end else begin
        tx_n     = wr_tx;
        pend_v_n = 1'b0;
      end
    end

    // Hardware events take priority over any software request.
    if (arb_hit) begin
      mst_n = 1'b0;
      tx_n  = 1'b0;
    end
    if (ovr_hit) begin
      mst_n = 1'b0;
    end
    if (rd_hit) begin
      tx_n = 1'b1;
    end
    if (hw_hit) begin
      pend_v_n = 1'b0;
    end
    if (!en) begin
      pend_v_n = 1'b0;
    end
  end

  always_comb begin
    in_frame_n = in_frame_q;
    if (ev_frame_end) in_frame_n = 1'b0;
    if (ev_start)     in_frame_n = 1'b1;
    if (!en)          in_frame_n = 1'b0;
  end

  assign enter_stx = (~mst_n & tx_n) & ~(~mst_q & tx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_q       <= 1'b0;
      tx_q        <= 1'b0;
      pend_v_q    <= 1'b0;
      pend_tx_q   <= 1'b0;
      in_frame_q  <= 1'b0;
      arb_pulse_q <= 1'b0;
    end else begin
      mst_q       <= mst_n;
      tx_q        <= tx_n;
      pend_v_q    <= pend_v_n;
      pend_tx_q   <= pend_tx_n;
      in_frame_q  <= in_frame_n;
      arb_pulse_q <= arb_hit;
    end
  end

endmodule

// File: rtl/sbus_setup_timer.sv
module sbus_setup_timer #(
  parameter int unsigned SHORT_CYC = 10,
  parameter int unsigned LONG_CYC  = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  input  logic abort,
  output logic busy_q
);

  localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LD_SHORT = CNT_W'(SHORT_CYC);
  localparam logic [CNT_W-1:0] LD_LONG  = CNT_W'(LONG_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= (long_sel ? LD_LONG : LD_SHORT) - CNT_W'(1);
      busy_q <= 1'b1;
    end else if (abort) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end else begin
      busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sbus_rx_gate.sv
module sbus_rx_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hold,
  input  logic tx,
  input  logic slave_rx,
  input  logic wr_en,
  input  logic wr_hold,
  input  logic ev_data_read,
  input  logic ev_addr_match,
  input  logic flag_clr,
  output logic rx_allow_q,
  output logic match_q
);

  logic block_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      block_q <= 1'b0;
    end else if (!en) begin
      block_q <= 1'b0;
    end else if (ev_data_read && !tx) begin
      block_q <= hold;
    end else if (wr_en && !wr_hold) begin
      block_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_allow_q <= 1'b0;
    end else if (!en) begin
      rx_allow_q <= 1'b0;
    end else if (ev_data_read && !tx) begin
      rx_allow_q <= ~hold;
    end else if (wr_en && !wr_hold) begin
      rx_allow_q <= 1'b1;
    end else begin
      rx_allow_q <= ~block_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
    end else if (en && ev_addr_match && slave_rx) begin
      match_q <= 1'b1;
    end else if (flag_clr) begin
      match_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sbus_mode_ctrl.sv
module sbus_mode_ctrl
  import sbus_mode_pkg::*;
#(
  parameter int unsigned SETUP_SHORT = 10,
  parameter int unsigned SETUP_LONG  = 20,
  parameter int unsigned CSEL_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              flag_clr,
  input  logic              fmt_sync,
  input  logic              ev_start,
  input  logic              ev_frame_end,
  input  logic              ev_addr_match,
  input  logic              ev_addr_rw,
  input  logic              ev_arb_lost,
  input  logic              ev_overrun,
  input  logic              ev_data_read,
  output logic [7:0]        ctrl_o,
  output logic [1:0]        mode_o,
  output logic              pin_drive_o,
  output logic              rx_allow_o,
  output logic              setup_wait_o,
  output logic [CSEL_W-1:0] clk_sel_o,
  output logic              arb_lost_o,
  output logic              match_flag_o
);

  localparam int unsigned LONG_BIT = CSEL_W - 1;

  logic              en_q;
  logic              hold_q;
  logic [CSEL_W-1:0] csel_q;
  logic              mst_q, tx_q;
  logic              enter_stx;
  logic              leave_stx;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      hold_q <= 1'b0;
      csel_q <= '0;
    end else if (wr_en) begin
      en_q   <= wr_data[CW_EN];
      hold_q <= wr_data[CW_HOLD];
      csel_q <= wr_data[CSEL_W-1:0];
    end
  end

  sbus_mode_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .en            (en_q),
    .wr_en         (wr_en),
    .wr_mst        (wr_data[CW_MST]),
    .wr_tx         (wr_data[CW_TX]),
    .fmt_sync      (fmt_sync),
    .ev_start      (ev_start),
    .ev_frame_end  (ev_frame_end),
    .ev_addr_match (ev_addr_match),
    .ev_addr_rw    (ev_addr_rw),
    .ev_arb_lost   (ev_arb_lost),
    .ev_overrun    (ev_overrun),
    .mst_q         (mst_q),
    .tx_q          (tx_q),
    .arb_pulse_q   (arb_lost_o),
    .enter_stx     (enter_stx)
  );

  assign leave_stx = ~(~mst_q & tx_q);

  sbus_setup_timer #(
    .SHORT_CYC (SETUP_SHORT),
    .LONG_CYC  (SETUP_LONG)
  ) u_setup (
    .clk      (clk),
    .rst      (rst),
    .start    (enter_stx),
    .long_sel (wr_en ? wr_data[LONG_BIT] : csel_q[LONG_BIT]),
    .abort    (leave_stx),
    .busy_q   (setup_wait_o)
  );

  sbus_rx_gate u_rx (
    .clk           (clk),
    .rst           (rst),
    .en            (en_q),
    .hold          (hold_q),
    .tx            (tx_q),
    .slave_rx      (~mst_q & ~tx_q),
    .wr_en         (wr_en),
    .wr_hold       (wr_data[CW_HOLD]),
    .ev_data_read  (ev_data_read),
    .ev_addr_match (ev_addr_match),
    .flag_clr      (flag_clr),
    .rx_allow_q    (rx_allow_o),
    .match_q       (match_flag_o)
  );

  generate
    if (CSEL_W >= 4) begin : g_ctrl_full
      assign ctrl_o = {en_q, hold_q, mst_q, tx_q, csel_q[3:0]};
    end else begin : g_ctrl_pad
      assign ctrl_o = {en_q, hold_q, mst_q, tx_q, {(4-CSEL_W){1'b0}}, csel_q};
    end
  endgenerate

  assign mode_o      = {mst_q, tx_q};
  assign pin_drive_o = en_q;
  assign clk_sel_o   = csel_q;

endmodule

// File: rtl/sbus_mode_ctrl_checker.sv
module sbus_mode_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       fmt_sync,
  input logic       ev_addr_match,
  input logic       ev_addr_rw,
  input logic       ev_arb_lost,
  input logic       ev_overrun,
  input logic [1:0] mode_o,
  input logic       pin_drive_o,
  input logic       setup_wait_o,
  input logic       arb_lost_o
);

  assert_arb_to_slave_R4: assert property (@(posedge clk) disable iff (rst)
    (pin_drive_o && ev_arb_lost && mode_o[1] && !fmt_sync) |=> (mode_o == 2'b00));

  assert_overrun_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (pin_drive_o && ev_overrun && mode_o == 2'b10 && fmt_sync) |=> (mode_o == 2'b00));

  assert_read_match_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_drive_o && ev_addr_match && ev_addr_rw && mode_o == 2'b00) |=> (mode_o == 2'b01));

  assert_setup_in_stx_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(setup_wait_o) |-> (mode_o == 2'b01));

  assert_arb_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
    arb_lost_o |=> !arb_lost_o);

  assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (rst)
    (!pin_drive_o && !wr_en) |=> $stable(mode_o));

endmodule

bind sbus_mode_ctrl sbus_mode_ctrl_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .fmt_sync      (fmt_sync),
  .ev_addr_match (ev_addr_match),
  .ev_addr_rw    (ev_addr_rw),
  .ev_arb_lost   (ev_arb_lost),
  .ev_overrun    (ev_overrun),
  .mode_o        (mode_o),
  .pin_drive_o   (pin_drive_o),
  .setup_wait_o  (setup_wait_o),
  .arb_lost_o    (arb_lost_o)
);

// File: tb/sbus_mode_ctrl_test.sv
`timescale 1ns/1ps
module sbus_mode_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       flag_clr = 1'b0;
  logic       fmt_sync = 1'b0;
  logic       ev_start = 1'b0, ev_frame_end = 1'b0;
  logic       ev_addr_match = 1'b0, ev_addr_rw = 1'b0;
  logic       ev_arb_lost = 1'b0, ev_overrun = 1'b0, ev_data_read = 1'b0;
  logic [7:0] ctrl_o;
  logic [1:0] mode_o;
  logic       pin_drive_o, rx_allow_o, setup_wait_o, arb_lost_o, match_flag_o;
  logic [3:0] clk_sel_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sbus_mode_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .fmt_sync(fmt_sync), .ev_start(ev_start), .ev_frame_end(ev_frame_end),
    .ev_addr_match(ev_addr_match), .ev_addr_rw(ev_addr_rw), .ev_arb_lost(ev_arb_lost),
    .ev_overrun(ev_overrun), .ev_data_read(ev_data_read), .ctrl_o(ctrl_o),
    .mode_o(mode_o), .pin_drive_o(pin_drive_o), .rx_allow_o(rx_allow_o),
    .setup_wait_o(setup_wait_o), .clk_sel_o(clk_sel_o), .arb_lost_o(arb_lost_o),
    .match_flag_o(match_flag_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clear_inputs();
    wr_en = 0; flag_clr = 0; ev_start = 0; ev_frame_end = 0; ev_addr_match = 0;
    ev_addr_rw = 0; ev_arb_lost = 0; ev_overrun = 0; ev_data_read = 0;
  endtask

  task automatic write_cw(input logic [7:0] v);
    wr_en = 1; wr_data = v;
    tick();
    clear_inputs();
  endtask

  task automatic t_reset();
    check("R1", "ctrl", ctrl_o, 0);
    check("R1", "mode", mode_o, 0);
    check("R1", "pin_drive", pin_drive_o, 0);
    check("R1", "rx_allow", rx_allow_o, 0);
    check("R1", "flags", {setup_wait_o, arb_lost_o, match_flag_o}, 0);
  endtask

  task automatic t_write_modes();
    write_cw(8'hB5);
    check("R2", "ctrl readback", ctrl_o, 8'hB5);
    check("R2", "clk_sel", clk_sel_o, 4'h5);
    check("R3", "mode master tx", mode_o, 2'b11);
    check("R3", "pin drive on", pin_drive_o, 1);
  endtask

  task automatic t_arb_lost();
    write_cw(8'hB0);
    fmt_sync = 0; ev_arb_lost = 1;
    tick(); clear_inputs();
    check("R4", "mode after arb lost", mode_o, 2'b00);
    check("R10", "arb pulse high", arb_lost_o, 1);
    tick();
    check("R10", "arb pulse one cycle", arb_lost_o, 0);
  endtask

  task automatic t_overrun();
    write_cw(8'hA0);
    fmt_sync = 0; ev_overrun = 1;
    tick(); clear_inputs();
    check("R5", "overrun two-wire ignored", mode_o, 2'b10);
    fmt_sync = 1; ev_overrun = 1;
    tick(); clear_inputs();
    check("R5", "overrun sync -> slave rx", mode_o, 2'b00);
    fmt_sync = 0;
  endtask

  task automatic t_setup_len(input logic [7:0] cw, input int exp_len);
    int len = 0;
    write_cw(cw);
    ev_addr_match = 1; ev_addr_rw = 1;
    tick(); clear_inputs();
    check("R6", "read match -> slave tx", mode_o, 2'b01);
    while (setup_wait_o && len < 100) begin
      len++;
      tick();
    end
    check("R8", "setup wait length", len, exp_len);
  endtask

  task automatic t_match_flag();
    write_cw(8'h80);
    flag_clr = 1; tick(); clear_inputs();
    ev_addr_match = 1; ev_addr_rw = 0;
    tick(); clear_inputs();
    check("R6", "write match keeps slave rx", mode_o, 2'b00);
    check("R10", "match flag set", match_flag_o, 1);
    tick();
    check("R10", "match flag sticky", match_flag_o, 1);
    flag_clr = 1; tick(); clear_inputs();
    check("R10", "match flag cleared", match_flag_o, 0);
  endtask

  task automatic t_pending_tx();
    write_cw(8'h80);
    ev_start = 1; tick(); clear_inputs();
    write_cw(8'h90);
    check("R7", "tx held during frame", mode_o, 2'b00);
    tick();
    check("R7", "tx still held", mode_o, 2'b00);
    ev_frame_end = 1; tick(); clear_inputs();
    check("R7", "tx applied at frame end", mode_o, 2'b01);
  endtask

  task automatic t_hw_priority();
    write_cw(8'hB0);
    wr_en = 1; wr_data = 8'hB0; ev_arb_lost = 1; fmt_sync = 0;
    tick(); clear_inputs();
    check("R9", "hw event beats write", mode_o, 2'b00);
  endtask

  task automatic t_rx_gate();
    write_cw(8'hC0);
    check("R11", "rx allowed initially", rx_allow_o, 1);
    ev_data_read = 1; tick(); clear_inputs();
    check("R11", "rx blocked after read", rx_allow_o, 0);
    tick();
    check("R11", "rx stays blocked", rx_allow_o, 0);
    write_cw(8'h80);
    check("R11", "rx reopened by write", rx_allow_o, 1);
    ev_data_read = 1; tick(); clear_inputs();
    check("R11", "read with hold 0 keeps rx", rx_allow_o, 1);
  endtask

  task automatic t_disabled();
    write_cw(8'h00);
    flag_clr = 1; tick(); clear_inputs();
    ev_addr_match = 1; ev_addr_rw = 1;
    tick(); clear_inputs();
    check("R12", "mode unchanged when off", mode_o, 2'b00);
    check("R12", "no match flag when off", match_flag_o, 0);
    check("R12", "pins released", pin_drive_o, 0);
    check("R12", "rx gate closed when off", rx_allow_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    tick();
    t_reset();
    t_write_modes();
    t_arb_lost();
    t_overrun();
    t_setup_len(8'h80, 10);
    t_setup_len(8'h88, 20);
    t_match_flag();
    t_pending_tx();
    t_hw_priority();
    t_rx_gate();
    t_disabled();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule